// File: doc/BRIEF.md
# Stack-Machine ALU with Single Condition Flag

This block is the arithmetic and logic stage of a stack-oriented processor. One operand comes from the register bus. The other is either the top-of-stack word or a 16-bit literal from the instruction, zero-extended. A 16-bit operation word steers the block.

A format bit selects between two operation classes:
- **Compute class:** a two-input Boolean function unit and an adder that also does both subtraction directions.
- **Step class:** one-bit left and right shifts, a conditional-add multiply step and a shift-and-conditional-subtract divide step.

A single flag register holds one bit, taken from one of sixteen conditions or from a step bit. That bit is reused in three ways:
- as the adder carry-in, for multiword arithmetic;
- as the shift-in bit;
- as a full-width truth value (all zeros or all ones) placed on the result.

The result is combinational. The flag is the only state.

Top module: `alu_flag_unit`

## Requirements
- R1: With op[15]=0 and op[6:5]=00, result bit i equals op[{b_in[i],B[i]}]. B is the second operand, and the two-bit index selects among op[3:0], so every one of the 16 two-input functions is reachable.
- R2: With op[15]=0, op[6:5] selects the adder mode: 01 computes b_in+B+cin, 10 computes b_in+~B+cin, and 11 computes ~b_in+B+cin, each kept to 32 bits. With op[8]=0 the carry-in cin is op[7].
- R3: With op[8]=1 in the compute class, cin is the current flag, so a carry saved by one operation feeds the next word of a multiword add.
- R4: When op[13]=1 in the compute class, the flag loads at the next rising edge the condition picked by op[12:9]. Z is result zero, N is result bit 31, C is adder carry-out and V is signed overflow; logic mode forces C=V=0. The codes are: 0 Z, 1 !Z, 2 N, 3 !N, 4 C, 5 !C, 6 V, 7 !V, 8 one, 9 zero, 10 C&!Z, 11 !C|Z, 12 N^V, 13 !(N^V), 14 !Z&!(N^V), 15 Z|(N^V).
- R5: When op[13]=0 the flag keeps its value across the clock edge.
- R6: When op[14]=1 the result is 32 copies of the flag's next value: the bit being loaded if op[13]=1, otherwise the held flag.
- R7: With op[15]=1, op[12:11]=00 shifts b_in left one place and 01 shifts it right one place. The vacated bit is the flag if op[10]=1, else 0. The step bit is the bit shifted out, and op[13]=1 loads it into the flag.
- R8: op[15]=1 with op[12:11]=10 is a multiply step. It adds B to b_in if the flag is 1 (adds nothing if 0), forming a 33-bit sum. The result is that sum shifted right by one, with the carry entering bit 31. The step bit is the sum's bit 0.
- R9: op[15]=1 with op[12:11]=11 is a divide step. It forms D as b_in shifted left with the op[10] shift-in rule, and the quotient bit q is b_in[31] OR (D >= B unsigned). The result is D-B when q=1 and D otherwise. The step bit is q.
- R10: With lit_sel=1, B is lit_in zero-extended to 32 bits; otherwise B is t_in.
- R11: While rst_n is low the flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| b_in | input | 32 | Register-bus operand |
| t_in | input | 32 | Top-of-stack operand |
| lit_sel | input | 1 | Use the literal instead of t_in as the second operand |
| lit_in | input | 16 | Instruction literal, zero-extended |
| op | input | 16 | Operation word |
| result | output | 32 | Combinational result |
| flag | output | 1 | Condition flag register |

## Verification
The result depends only on the current inputs and the current flag, so it is due in the same cycle as the stimulus. The bench drives inputs on the falling edge and samples the result one nanosecond later. A flag load takes effect at the following rising edge, so the flag is sampled one nanosecond after that edge and compared with the value a bench model predicted from the previous cycle. Multiword carry chaining and multiply steps are sequences where one operation's flag feeds the next; they are checked back to back across consecutive cycles.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [1:0] {
    U_BOOL = 2'b00,
    U_ADD  = 2'b01,
    U_SUBA = 2'b10,
    U_SUBB = 2'b11
  } unit_e;

  typedef enum logic [1:0] {
    S_SHL  = 2'b00,
    S_SHR  = 2'b01,
    S_MUL  = 2'b10,
    S_DIV  = 2'b11
  } step_e;

  localparam int OPW = 16;
endpackage

// File: rtl/alu_bool_unit.sv
module alu_bool_unit #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [3:0]   fn,
  output logic [W-1:0] y
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign y[i] = fn[{a[i], b[i]}];
  end
endmodule

// File: rtl/alu_adder.sv
module alu_adder #(
  parameter int W = 32
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         ovf
);
  logic [W:0] full;

  always_comb begin
    full = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};
    sum  = full[W-1:0];
    cout = full[W];
    ovf  = (x[W-1] == y[W-1]) && (full[W-1] != x[W-1]);
  end
endmodule

// File: rtl/alu_step_unit.sv
module alu_step_unit
  import alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sin,
  input  logic         fcur,
  input  step_e        kind,
  output logic [W-1:0] res,
  output logic         sbit
);
  logic [W:0]   acc;
  logic [W-1:0] dsh;
  logic [W:0]   diff;
  logic         qbit;

  always_comb begin
    acc  = {1'b0, a} + (fcur ? {1'b0, b} : {(W+1){1'b0}});
    dsh  = {a[W-2:0], sin};
    diff = {1'b0, dsh} - {1'b0, b};
    qbit = a[W-1] | ~diff[W];
    unique case (kind)
      S_SHL: begin
        res  = {a[W-2:0], sin};
        sbit = a[W-1];
      end
      S_SHR: begin
        res  = {sin, a[W-1:1]};
        sbit = a[0];
      end
      S_MUL: begin
        res  = acc[W:1];
        sbit = acc[0];
      end
      default: begin
        res  = qbit ? diff[W-1:0] : dsh;
        sbit = qbit;
      end
    endcase
  end
endmodule

// File: rtl/alu_cond_sel.sv
module alu_cond_sel #(
  parameter int W = 32
) (
  input  logic [W-1:0] val,
  input  logic         c,
  input  logic         v,
  input  logic [3:0]   code,
  output logic         hit
);
  logic z, n, lt;

  always_comb begin
    z  = (val == '0);
    n  = val[W-1];
    lt = n ^ v;
    unique case (code)
      4'd0:    hit = z;
      4'd1:    hit = ~z;
      4'd2:    hit = n;
      4'd3:    hit = ~n;
      4'd4:    hit = c;
      4'd5:    hit = ~c;
      4'd6:    hit = v;
      4'd7:    hit = ~v;
      4'd8:    hit = 1'b1;
      4'd9:    hit = 1'b0;
      4'd10:   hit = c & ~z;
      4'd11:   hit = ~c | z;
      4'd12:   hit = lt;
      4'd13:   hit = ~lt;
      4'd14:   hit = ~z & ~lt;
      default: hit = z | lt;
    endcase
  end
endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
  import alu_pkg::*;
#(
  parameter int W    = 32,
  parameter int LITW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [W-1:0]    b_in,
  input  logic [W-1:0]    t_in,
  input  logic            lit_sel,
  input  logic [LITW-1:0] lit_in,
  input  logic [OPW-1:0]  op,
  output logic [W-1:0]    result,
  output logic            flag
);
  localparam int PADW = W - LITW;

  // operation word fields
  logic       is_step, flag_to_bus, flag_load, cin_from_flag, cin_const, sin_from_flag;
  logic [3:0] cond_code, bool_fn;
  unit_e      unit;
  step_e      skind;

  assign is_step       = op[15];
  assign flag_to_bus   = op[14];
  assign flag_load     = op[13];
  assign cond_code     = op[12:9];
  assign cin_from_flag = op[8];
  assign cin_const     = op[7];
  assign unit          = unit_e'(op[6:5]);
  assign bool_fn       = op[3:0];
  assign skind         = step_e'(op[12:11]);
  assign sin_from_flag = op[10];

  logic         flag_q, flag_d;
  logic [W-1:0] opnd_b, bool_y, add_x, add_y, add_sum, cmp_res, step_res, core_res;
  logic         add_c, add_v, cmp_c, cmp_v, cond_hit, step_bit, new_bit, cin;

  assign opnd_b = lit_sel ? {{PADW{1'b0}}, lit_in} : t_in;
  assign cin    = cin_from_flag ? flag_q : cin_const;

  always_comb begin
    unique case (unit)
      U_SUBA:  begin add_x = b_in;  add_y = ~opnd_b; end
      U_SUBB:  begin add_x = ~b_in; add_y = opnd_b;  end
      default: begin add_x = b_in;  add_y = opnd_b;  end
    endcase
  end

  alu_bool_unit #(.W(W)) u_bool (
    .a(b_in), .b(opnd_b), .fn(bool_fn), .y(bool_y)
  );

  alu_adder #(.W(W)) u_add (
    .x(add_x), .y(add_y), .cin(cin), .sum(add_sum), .cout(add_c), .ovf(add_v)
  );

  always_comb begin
    if (unit == U_BOOL) begin
      cmp_res = bool_y;
      cmp_c   = 1'b0;
      cmp_v   = 1'b0;
    end else begin
      cmp_res = add_sum;
      cmp_c   = add_c;
      cmp_v   = add_v;
    end
  end

  alu_cond_sel #(.W(W)) u_cond (
    .val(cmp_res), .c(cmp_c), .v(cmp_v), .code(cond_code), .hit(cond_hit)
  );

  alu_step_unit #(.W(W)) u_step (
    .a(b_in), .b(opnd_b), .sin(sin_from_flag & flag_q), .fcur(flag_q),
    .kind(skind), .res(step_res), .sbit(step_bit)
  );

  // next-state and output selection
  always_comb begin
    core_res = is_step ? step_res : cmp_res;
    new_bit  = is_step ? step_bit : cond_hit;
    flag_d   = flag_load ? new_bit : flag_q;
    result   = flag_to_bus ? {W{flag_d}} : core_res;
  end

  // flag register; rst_n is expected to be released synchronously upstream
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else if (flag_load) flag_q <= flag_d;
  end

  assign flag = flag_q;
endmodule

// File: rtl/alu_flag_unit_chk.sv
module alu_flag_unit_chk #(
  parameter int W    = 32,
  parameter int LITW = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic [W-1:0]    b_in,
  input logic [W-1:0]    t_in,
  input logic            lit_sel,
  input logic [LITW-1:0] lit_in,
  input logic [15:0]     op,
  input logic [W-1:0]    result,
  input logic            flag
);
  // R5: no load request keeps the flag
  p_flag_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !op[13] |=> flag == $past(flag));

  // R6: flag on the bus is a full-width truth value
  p_truth_width_r6: assert property (@(posedge clk) disable iff (!rst_n)
    op[14] |-> (result == '0 || result == '1));

  // R6: the truth value shown equals what the flag becomes
  p_truth_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op[14] && op[13]) |=> flag == $past(result[0]));

  // R7: left shift loads the bit shifted out of the top
  p_shl_out_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (op[15] && op[12:11] == 2'b00 && op[13]) |=> flag == $past(b_in[W-1]));

  // R1: function code 1000 gives bitwise AND of the operands
  p_bool_and_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!op[15] && !op[14] && op[6:5] == 2'b00 && op[3:0] == 4'b1000 && !lit_sel)
      |-> result == (b_in & t_in));

  // R7: right shift with zero fill clears bit 31
  p_shr_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (op[15] && !op[14] && op[12:11] == 2'b01 && !op[10]) |-> !result[W-1]);
endmodule

bind alu_flag_unit alu_flag_unit_chk #(.W(W), .LITW(LITW)) u_chk (
  .clk(clk), .rst_n(rst_n), .b_in(b_in), .t_in(t_in), .lit_sel(lit_sel),
  .lit_in(lit_in), .op(op), .result(result), .flag(flag)
);

// File: tb/alu_flag_unit_test.sv
module alu_flag_unit_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] b_in, t_in;
  logic        lit_sel;
  logic [15:0] lit_in, op;
  logic [31:0] result;
  logic        flag;

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  logic        fmodel;
  logic [31:0] last_res;

  always #5 clk = ~clk;

  alu_flag_unit uut (
    .clk(clk), .rst_n(rst_n), .b_in(b_in), .t_in(t_in), .lit_sel(lit_sel),
    .lit_in(lit_in), .op(op), .result(result), .flag(flag)
  );

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [15:0] mk_cmp(logic fo, logic ld, logic [3:0] cc,
      logic cf, logic ck, logic [1:0] un, logic [3:0] fn);
    return {1'b0, fo, ld, cc, cf, ck, un, 1'b0, fn};
  endfunction

  function automatic logic [15:0] mk_step(logic fo, logic ld, logic [1:0] k, logic sf);
    return {1'b1, fo, ld, k, sf, 10'd0};
  endfunction

  // returns {step/condition bit, core result}
  function automatic logic [32:0] ref_eval(logic [15:0] o, logic [31:0] a,
      logic [31:0] bb, logic f);
    logic [31:0] r = '0;
    logic [32:0] s = '0;
    logic bitv = 1'b0, c = 1'b0, v = 1'b0, cin, z, n, lt, sin, q;
    logic [31:0] d;
    if (!o[15]) begin
      cin = o[8] ? f : o[7];
      case (o[6:5])
        2'd0: for (int i = 0; i < 32; i++) r[i] = o[{a[i], bb[i]}];
        2'd1: begin s = {1'b0,a} + {1'b0,bb} + 33'(cin); v = (a[31]==bb[31]) && (s[31]!=a[31]); end
        2'd2: begin s = {1'b0,a} + {1'b0,~bb} + 33'(cin); v = (a[31]!=bb[31]) && (s[31]!=a[31]); end
        default: begin s = {1'b0,~a} + {1'b0,bb} + 33'(cin); v = (a[31]!=bb[31]) && (s[31]!=bb[31]); end
      endcase
      if (o[6:5] != 2'd0) begin r = s[31:0]; c = s[32]; end
      z = (r == 0); n = r[31]; lt = n ^ v;
      case (o[12:9])
        4'd0: bitv = z;       4'd1: bitv = !z;
        4'd2: bitv = n;       4'd3: bitv = !n;
        4'd4: bitv = c;       4'd5: bitv = !c;
        4'd6: bitv = v;       4'd7: bitv = !v;
        4'd8: bitv = 1;       4'd9: bitv = 0;
        4'd10: bitv = c && !z; 4'd11: bitv = !c || z;
        4'd12: bitv = lt;     4'd13: bitv = !lt;
        4'd14: bitv = !z && !lt;
        default: bitv = z || lt;
      endcase
    end else begin
      sin = o[10] ? f : 1'b0;
      case (o[12:11])
        2'd0: begin r = (a << 1) | 32'(sin); bitv = a[31]; end
        2'd1: begin r = (a >> 1) | ({31'd0, sin} << 31); bitv = a[0]; end
        2'd2: begin s = {1'b0,a} + (f ? {1'b0,bb} : 33'd0); r = s[32:1]; bitv = s[0]; end
        default: begin
          d = (a << 1) | 32'(sin);
          q = a[31] || (d >= bb);
          r = q ? d - bb : d;
          bitv = q;
        end
      endcase
    end
    return {bitv, r};
  endfunction

  function automatic string tag_of(logic [15:0] o, logic ls);
    if (o[14]) return "R6";
    if (o[15]) return (o[12:11] == 2'd2) ? "R8" : (o[12:11] == 2'd3) ? "R9" : "R7";
    if (ls) return "R10";
    if (o[6:5] == 2'd0) return "R1";
    if (o[8]) return "R3";
    if (o[13]) return "R4";
    return "R2";
  endfunction

  task automatic run(logic [31:0] a, logic [31:0] t, logic ls, logic [15:0] lit,
      logic [15:0] o);
    logic [32:0] e;
    logic [31:0] bb;
    logic fnew;
    string tg;
    @(negedge clk);
    b_in = a; t_in = t; lit_sel = ls; lit_in = lit; op = o;
    #1;
    bb = ls ? {16'd0, lit} : t;
    e = ref_eval(o, a, bb, fmodel);
    fnew = o[13] ? e[32] : fmodel;
    tg = tag_of(o, ls);
    last_res = result;
    check({tg, " result"}, result, o[14] ? {32{fnew}} : e[31:0]);
    @(posedge clk);
    #1;
    check(o[13] ? {tg, " flag load"} : "R5 flag hold", {31'd0, flag}, {31'd0, fnew});
    fmodel = fnew;
  endtask

  function automatic logic [31:0] pick();
    case ($urandom % 6)
      0: return 32'h0;
      1: return 32'hFFFF_FFFF;
      2: return 32'h7FFF_FFFF;
      3: return 32'h8000_0000;
      default: return $urandom;
    endcase
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    rst_n = 1'b0; b_in = '0; t_in = '0; lit_sel = 1'b0; lit_in = '0; op = '0;
    fmodel = 1'b0;
    repeat (2) @(posedge clk);
    #1 check("R11 reset flag", {31'd0, flag}, 32'd0);
    @(negedge clk) rst_n = 1'b1;

    // R1: AND and XOR codes, then all sixteen functions
    run(32'hFF00_FF00, 32'h0F0F_0F0F, 0, 0, mk_cmp(0, 0, 0, 0, 0, 2'd0, 4'b1000));
    check("R1 and", last_res, 32'h0F00_0F00);
    run(32'hFF00_FF00, 32'h0F0F_0F0F, 0, 0, mk_cmp(0, 0, 0, 0, 0, 2'd0, 4'b0110));
    check("R1 xor", last_res, 32'hF00F_F00F);
    for (int k = 0; k < 16; k++)
      run(32'hCCCC_3333, 32'hAAAA_5555, 0, 0, mk_cmp(0, 0, 0, 0, 0, 2'd0, 4'(k)));

    // R4 then R3: 64-bit add carried through the flag
    run(32'hFFFF_FFFF, 32'h1, 0, 0, mk_cmp(0, 1, 4'd4, 0, 0, 2'd1, 0));
    check("R2 low word", last_res, 32'h0);
    check("R4 carry flag", {31'd0, flag}, 32'd1);
    run(32'd5, 32'd7, 0, 0, mk_cmp(0, 0, 0, 1, 0, 2'd1, 0));
    check("R3 high word", last_res, 32'd13);

    // R4: signed overflow condition
    run(32'h7FFF_FFFF, 32'h1, 0, 0, mk_cmp(0, 1, 4'd6, 0, 0, 2'd1, 0));
    check("R4 overflow flag", {31'd0, flag}, 32'd1);

    // R5: hold across an unloaded op
    run(32'h0, 32'h0, 0, 0, mk_cmp(0, 0, 4'd9, 0, 0, 2'd1, 0));
    check("R5 hold", {31'd0, flag}, 32'd1);

    // R6: load zero condition of a zero result and show it
    run(32'h0, 32'h0, 0, 0, mk_cmp(1, 1, 4'd0, 0, 0, 2'd1, 0));
    check("R6 truth", last_res, 32'hFFFF_FFFF);

    // R10: literal operand
    run(32'h0, 32'hDEAD_BEEF, 1, 16'hABCD, mk_cmp(0, 0, 0, 0, 0, 2'd1, 0));
    check("R10 literal", last_res, 32'h0000_ABCD);

    // R8: multiply step with flag set
    run(32'hFFFF_FFFF, 32'h1, 0, 0, mk_step(0, 1, 2'd2, 0));
    check("R8 mul step", last_res, 32'h8000_0000);

    // R9: divide step where the shifted value reaches the divisor
    run(32'h0000_0003, 32'h5, 0, 0, mk_step(0, 1, 2'd3, 0));
    check("R9 div step", last_res, 32'h1);

    // random mix across all classes
    for (int i = 0; i < 3000; i++)
      run(pick(), pick(), 1'($urandom), 16'($urandom), 16'($urandom));

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule